// File: doc/BRIEF.md
# Load-Use Pipeline Interlock

This block decides, every cycle, whether a five-stage in-order pipeline must pause for one cycle because a load sitting in the execute stage writes a register that the instruction being decoded is about to read. Load data only exists once the memory stage has finished. A consumer that needs the value in execute on the very next cycle cannot be served by any bypass, so the consumer is held back once.

When such a dependency is seen, the block holds the program counter and the fetch/decode register and turns the decode/execute slot into a bubble. The bubble clears every write and memory enable and leaves the data fields untouched, then travels to write-back as an empty slot. After that single cycle the bubble is in execute, the hazard is gone, and the consumer carries on. All other dependencies are left to the forwarding network or to the register file's write-then-read behaviour within one cycle. These include ALU results, loads two or more slots back, and a store that uses the loaded register only as the data to be stored.

The stall outputs are combinational functions of the current pipeline register contents. The surrounding pipeline applies them at its next clock edge. The clock and reset inputs are used only by the embedded checks.

Top module: `luh_interlock`

## Requirements
- R1: When `ex_is_load` is 1, `ex_rd` is not 0, `id_rs1_used` is 1 and `id_rs1` equals `ex_rd`, the block stalls: `pc_write`=0, `ifid_write`=0 and `idex_bubble`=1.
- R2: When `ex_is_load` is 1, `ex_rd` is not 0, `id_rs2_used` is 1, `id_is_store` is 0 and `id_rs2` equals `ex_rd`, the block stalls as in R1.
- R3: A load whose destination `ex_rd` is register 0 never causes a stall, even if a used source field is 0.
- R4: When `ex_is_load` is 0, the block never stalls, whatever the register fields hold. This covers an ALU producer in execute and the bubble that follows a stall.
- R5: A source field whose use flag is 0 is ignored: a match on it alone gives no stall.
- R6: When `id_is_store` is 1, a match on `id_rs2` (the store data) alone gives no stall. A match on `id_rs1` (the address base) still stalls.
- R7: Without a hazard, `pc_write`=1, `ifid_write`=1 and `idex_bubble`=0. `pc_write` and `ifid_write` are always equal, and `idex_bubble` is always their inverse.
- R8: The outputs respond in the same cycle in which the inputs are applied, with no register between them. With a bubble in execute on the following cycle, a stall lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the embedded checks |
| rst_n | input | 1 | Active-low reset, disables the checks |
| id_rs1 | input | AW | First source register of the decode-stage instruction |
| id_rs1_used | input | 1 | First source is actually read |
| id_rs2 | input | AW | Second source register of the decode-stage instruction |
| id_rs2_used | input | 1 | Second source is actually read |
| id_is_store | input | 1 | Decode-stage instruction is a store; the second source is its data |
| ex_rd | input | AW | Destination register of the execute-stage instruction |
| ex_is_load | input | 1 | Execute-stage instruction is a load |
| pc_write | output | 1 | 1 lets the program counter advance, 0 holds it |
| ifid_write | output | 1 | 1 lets the fetch/decode register load, 0 holds it |
| idex_bubble | output | 1 | 1 clears the enables of the decode/execute slot |

## Verification
The one-cycle stall check assumes that the surrounding pipeline obeys the outputs. After any cycle in which `pc_write` is 0, the execute stage must hold the bubble, so `ex_is_load` must be 0 on the next cycle. The bench's driver keeps to this by following every stimulus whose expected outcome is a stall with a cycle in which only the load flag is cleared. The other checks take any input combination. The stimulus drives each field once per cycle, one time unit after the rising edge, so that the inputs hold steady while the checks sample them.

// File: rtl/luh_pkg.sv
package luh_pkg;

  // Which decode-stage source, if any, depends on the load in execute
  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_SRC1 = 2'd1,
    CAUSE_SRC2 = 2'd2,
    CAUSE_BOTH = 2'd3
  } cause_t;

  function automatic cause_t cause_of(input logic hit1, input logic hit2);
    cause_t c;
    c = cause_t'({hit2, hit1});
    return c;
  endfunction

  // A hazard needs a load producer and at least one dependent source
  function automatic logic needs_stall(input logic is_load, input cause_t c);
    return is_load && (c != CAUSE_NONE);
  endfunction

endpackage

// File: rtl/luh_src_match.sv
module luh_src_match #(
  parameter int AW       = 5,
  parameter int ZERO_IDX = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] src,
  input  logic          src_live,
  input  logic [AW-1:0] dst,
  output logic          hit
);

  localparam logic [AW-1:0] ZERO_REG = AW'(ZERO_IDX);

  logic dst_real;
  logic same_reg;

  assign dst_real = (dst != ZERO_REG);
  assign same_reg = (src == dst);
  assign hit      = src_live && dst_real && same_reg;

  // R5: a source that is not read never reports a dependency
  assert_unused_src_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !src_live |-> !hit);

  // R3: the hard-wired zero register never forms a dependency
  assert_zero_dst_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dst == ZERO_REG) |-> !hit);

endmodule

// File: rtl/luh_stall_ctrl.sv
module luh_stall_ctrl
  import luh_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ex_is_load,
  input  logic hit1,
  input  logic hit2,
  output logic pc_write,
  output logic ifid_write,
  output logic idex_bubble
);

  cause_t cause;
  logic   stall;

  assign cause       = cause_of(hit1, hit2);
  assign stall       = needs_stall(ex_is_load, cause);
  assign pc_write    = !stall;
  assign ifid_write  = !stall;
  assign idex_bubble = stall;

  // R4: only a load producer can pause the front end
  assert_nonload_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_is_load |-> (pc_write && !idex_bubble));

  // R7: both holds move together and the bubble is their inverse
  assert_outputs_agree_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_write == ifid_write) && (idex_bubble == !ifid_write));

  // R8: with the bubble in execute next cycle, a stall never repeats
  assert_single_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_write |=> pc_write);

endmodule

// File: rtl/luh_interlock.sv
module luh_interlock #(
  parameter int AW       = 5,
  parameter int ZERO_IDX = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] id_rs1,
  input  logic          id_rs1_used,
  input  logic [AW-1:0] id_rs2,
  input  logic          id_rs2_used,
  input  logic          id_is_store,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_is_load,
  output logic          pc_write,
  output logic          ifid_write,
  output logic          idex_bubble
);

  localparam int NSRC = 2;

  logic [AW-1:0] src_idx  [NSRC];
  logic          src_live [NSRC];
  logic [NSRC-1:0] src_hit;

  // A store reads its second source only as data, which the
  // memory-stage bypass supplies, so that source is not live here
  assign src_idx[0]  = id_rs1;
  assign src_live[0] = id_rs1_used;
  assign src_idx[1]  = id_rs2;
  assign src_live[1] = id_rs2_used && !id_is_store;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    luh_src_match #(.AW(AW), .ZERO_IDX(ZERO_IDX)) u_match (
      .clk      (clk),
      .rst_n    (rst_n),
      .src      (src_idx[g]),
      .src_live (src_live[g]),
      .dst      (ex_rd),
      .hit      (src_hit[g])
    );
  end

  luh_stall_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .ex_is_load  (ex_is_load),
    .hit1        (src_hit[0]),
    .hit2        (src_hit[1]),
    .pc_write    (pc_write),
    .ifid_write  (ifid_write),
    .idex_bubble (idex_bubble)
  );

  // R1: address/first-operand dependency on a load stalls
  assert_src1_stall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_is_load && id_rs1_used && (id_rs1 == ex_rd) && (ex_rd != AW'(ZERO_IDX)))
      |-> (!pc_write && idex_bubble));

  // R2: second-operand dependency on a load stalls unless it is store data
  assert_src2_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_is_load && id_rs2_used && !id_is_store && (id_rs2 == ex_rd) &&
     (ex_rd != AW'(ZERO_IDX))) |-> (!pc_write && idex_bubble));

  // R6: store data alone never holds the front end
  assert_store_data_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (id_is_store && !(id_rs1_used && (id_rs1 == ex_rd))) |-> pc_write);

endmodule

// File: tb/tb_luh_interlock.sv
`timescale 1ns/1ps
module tb_luh_interlock;

  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] id_rs1 = '0, id_rs2 = '0, ex_rd = '0;
  logic          id_rs1_used = 1'b0, id_rs2_used = 1'b0, id_is_store = 1'b0, ex_is_load = 1'b0;
  logic          pc_write, ifid_write, idex_bubble;

  always #2 clk = ~clk;  // 250 MHz

  luh_interlock #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n),
    .id_rs1(id_rs1), .id_rs1_used(id_rs1_used),
    .id_rs2(id_rs2), .id_rs2_used(id_rs2_used),
    .id_is_store(id_is_store),
    .ex_rd(ex_rd), .ex_is_load(ex_is_load),
    .pc_write(pc_write), .ifid_write(ifid_write), .idex_bubble(idex_bubble)
  );

  typedef struct {
    logic [2:0] outs;   // {pc_write, ifid_write, idex_bubble}
    string      tag;
  } item_t;

  item_t q[$];
  int    checks = 0;
  int    errors = 0;
  bit    done   = 1'b0;

  // Expected stall, written from the requirements
  function automatic bit model_stall(logic [AW-1:0] a, bit ua, logic [AW-1:0] b, bit ub,
                                     bit st, logic [AW-1:0] d, bit ld);
    bit dep_a, dep_b;
    if (!ld) return 1'b0;            // R4
    if (d == '0) return 1'b0;         // R3
    dep_a = ua && (a == d);           // R1, R5
    dep_b = ub && !st && (b == d);    // R2, R5, R6
    return dep_a || dep_b;
  endfunction

  task automatic step(logic [AW-1:0] a, bit ua, logic [AW-1:0] b, bit ub,
                      bit st, logic [AW-1:0] d, bit ld, string tag, output bit stalled);
    item_t it;
    @(posedge clk);
    #1;
    id_rs1 = a; id_rs1_used = ua; id_rs2 = b; id_rs2_used = ub;
    id_is_store = st; ex_rd = d; ex_is_load = ld;
    stalled = model_stall(a, ua, b, ub, st, d, ld);
    it.outs = stalled ? 3'b001 : 3'b110;
    it.tag  = tag;
    q.push_back(it);
  endtask

  // Any stall is followed by the bubble reaching execute (R8 input rule)
  task automatic vec(logic [AW-1:0] a, bit ua, logic [AW-1:0] b, bit ub,
                     bit st, logic [AW-1:0] d, bit ld, string tag);
    bit s, s2;
    step(a, ua, b, ub, st, d, ld, tag, s);
    if (s) step(a, ua, b, ub, st, d, 1'b0, "R8 bubble in EX releases stall", s2);
  endtask

  // Monitor: samples mid-cycle, after the driver has settled the inputs
  initial begin
    forever begin
      @(posedge clk);
      #3;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if ({pc_write, ifid_write, idex_bubble} !== it.outs) begin
          errors++;
          $display("FAIL %s: got %b expected %b", it.tag,
                   {pc_write, ifid_write, idex_bubble}, it.outs);
        end
      end
    end
  end

  initial begin
    bit s;
    // reset state: quiet inputs give no stall (R7)
    step(5'd0, 0, 5'd0, 0, 0, 5'd0, 0, "R7 reset state", s);
    step(5'd0, 0, 5'd0, 0, 0, 5'd0, 0, "R7 reset state", s);
    @(posedge clk); #1 rst_n = 1'b1;

    vec(5'd3, 1, 5'd9,  1, 0, 5'd3,  1, "R1 load then use on src1");
    vec(5'd4, 1, 5'd12, 1, 0, 5'd12, 1, "R2 load then use on src2");
    vec(5'd7, 1, 5'd7,  1, 0, 5'd7,  1, "R1 R2 both sources match");
    vec(5'd31,1, 5'd1,  1, 0, 5'd31, 1, "R1 top register index");
    vec(5'd0, 1, 5'd0,  1, 0, 5'd0,  1, "R3 load to r0 with r0 sources");
    vec(5'd3, 1, 5'd9,  1, 0, 5'd3,  0, "R4 ALU producer is forwarded");
    vec(5'd12,1, 5'd12, 1, 0, 5'd12, 0, "R4 ALU producer both match");
    vec(5'd5, 0, 5'd2,  1, 0, 5'd5,  1, "R5 unused src1 ignored");
    vec(5'd2, 1, 5'd6,  0, 0, 5'd6,  1, "R5 unused src2 ignored");
    vec(5'd8, 0, 5'd8,  0, 0, 5'd8,  1, "R5 no sources read");
    vec(5'd1, 1, 5'd10, 1, 1, 5'd10, 1, "R6 store data only does not stall");
    vec(5'd10,1, 5'd3,  1, 1, 5'd10, 1, "R6 store base still stalls");
    vec(5'd11,1, 5'd11, 1, 1, 5'd11, 1, "R6 store base and data match");
    vec(5'd1, 1, 5'd2,  1, 0, 5'd3,  1, "R7 load with no dependency");
    vec(5'd14,1, 5'd15, 1, 0, 5'd13, 1, "R7 neighbouring indices");
    vec(5'd0, 0, 5'd0,  0, 0, 5'd0,  0, "R7 idle slot");
    // R8: back-to-back different patterns, each answered in its own cycle
    vec(5'd20,1, 5'd0,  0, 0, 5'd20, 1, "R8 same-cycle response stall");
    vec(5'd20,1, 5'd0,  0, 0, 5'd21, 1, "R8 same-cycle response free");
    vec(5'd6, 1, 5'd6,  1, 0, 5'd6,  1, "R8 stall after free cycle");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule